// File: doc/BRIEF.md
# Write-Masked Pin Configuration Register Bank

This block holds a small bank of pin configuration registers. Each register stores 16 live bits that drive pad controls such as function select, bias, drive strength and input hysteresis. The stored values of all registers are always visible on one flat output bus, which the pad control logic decodes.

Every write is a 32-bit word. The upper half of the word is a per-bit enable for the lower half. A lower bit changes only where its enable bit is set, so software can update one field with a single write and no read first. A 2-bit per-pin field for pin p sits at bits 2*(p%8)+1 : 2*(p%8) and is updated by a write whose enable covers exactly those two bits. A 1-bit control is updated with one enable bit at position bit+16 and its value at position bit.

The bus is a simple synchronous port with a byte address, write data, a write strobe, a read strobe and registered read data. Registers sit on a 4-byte stride starting at address 0.

Top module: `cfgbank_top`

## Requirements
- R1: A synchronous active-high reset clears every stored bit and the read data to zero.
- R2: On a write to a valid address, stored bit n takes wdata[n] when wdata[n+16] is 1 and keeps its old value when wdata[n+16] is 0.
- R3: A write whose upper half is all zero leaves the addressed register unchanged.
- R4: A write changes only the register at index addr/4; all other registers keep their values.
- R5: A write is ignored when addr[1:0] is not zero or when addr/4 is NUM_REGS or more; a read of such an address returns zero.
- R6: A read returns the stored 16 bits in rdata[15:0] and zeros in rdata[31:16], in the cycle after the read strobe; rdata holds its value while no read is strobed.
- R7: cfg_flat[16k+15:16k] shows register k and reflects a write in the cycle after the write strobe.
- R8: When a read and a write hit the same register in one cycle, the read returns the value held before that write.
- R9: A 2-bit field for pin p, written with enable 2'b11 at bits 2*(p%8)+17 : 2*(p%8)+16, changes only bits 2*(p%8)+1 : 2*(p%8) of its register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address, word aligned |
| wdata | input | 32 | Enable bits in 31:16, data in 15:0 |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data, zero in 31:16 |
| cfg_flat | output | NUM_REGS*16 | Stored value of every register, register k at 16k |

## Verification
A write is captured on the rising edge where the strobe is seen and is visible on cfg_flat one edge later, while read data lands in rdata on the edge that sees the read strobe. The bench drives every input on the falling edge and samples on the following falling edge, so each sample sits half a cycle after the one register stage that both paths pass through. For a read and a write in the same cycle, rdata is compared with the model value from before the write and cfg_flat with the value after it, both at that same falling edge.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;

    typedef logic [HALF_W-1:0] half_t;

    // A write word split into its enable half and its data half.
    typedef struct packed {
        half_t mask;
        half_t val;
    } wr_word_t;

    typedef struct packed {
        half_t val;
    } cell_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
    } rd_state_t;

endpackage

// File: rtl/cfgbank_addr_dec.sv
module cfgbank_addr_dec #(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel,
    output logic                hit
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             aligned;

    assign idx     = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign hit     = aligned && (int'(idx) < NUM_REGS);

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
        assign sel[k] = hit && (idx == IDX_W'(k));
    end

endmodule

// File: rtl/cfgbank_cell.sv
module cfgbank_cell
    import cfgbank_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  wr_word_t wr,
    output half_t    val
);
    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.val = (st_q.val & ~wr.mask) | (wr.val & wr.mask);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val = st_q.val;

    // R2: bits without an enable keep their old value
    a_r2_unmasked_keep: assert property (@(posedge clk) disable iff (rst)
        we |=> (((val ^ $past(val)) & ~$past(wr.mask)) == '0));

    // R2: bits with an enable take the written value
    a_r2_masked_take: assert property (@(posedge clk) disable iff (rst)
        we |=> (((val ^ $past(wr.val)) & $past(wr.mask)) == '0));

    // R4: a register not selected holds
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(val));

endmodule

// File: rtl/cfgbank_rdport.sv
module cfgbank_rdport
    import cfgbank_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd_en,
    input  logic [NUM_REGS-1:0]        sel,
    input  logic [NUM_REGS*HALF_W-1:0] flat,
    output logic [WORD_W-1:0]          rdata
);
    rd_state_t st_d, st_q;
    half_t     pick;

    always_comb begin
        pick = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (sel[k]) begin
                pick = pick | flat[k*HALF_W +: HALF_W];
            end
        end
        st_d = st_q;
        if (rd_en) begin
            st_d.data = {{HALF_W{1'b0}}, pick};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.data;

    // R6: read data holds without a read strobe
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    // R6: mask half never shows on reads
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rdata[WORD_W-1:HALF_W] == '0);

endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
    import cfgbank_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [WORD_W-1:0]          wdata,
    input  logic                       wr_en,
    input  logic                       rd_en,
    output logic [WORD_W-1:0]          rdata,
    output logic [NUM_REGS*HALF_W-1:0] cfg_flat
);
    logic [NUM_REGS-1:0] sel;
    logic                hit;
    wr_word_t            wr;

    assign wr = wr_word_t'(wdata);

    cfgbank_addr_dec #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) u_dec (
        .addr (addr),
        .sel  (sel),
        .hit  (hit)
    );

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_cell
        cfgbank_cell u_cell (
            .clk (clk),
            .rst (rst),
            .we  (wr_en && sel[k]),
            .wr  (wr),
            .val (cfg_flat[k*HALF_W +: HALF_W])
        );
    end

    cfgbank_rdport #(
        .NUM_REGS (NUM_REGS)
    ) u_rd (
        .clk   (clk),
        .rst   (rst),
        .rd_en (rd_en),
        .sel   (sel),
        .flat  (cfg_flat),
        .rdata (rdata)
    );

    // Checking state: reset seen on the previous edge.
    logic rst_seen_q;
    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    // R1: one edge of reset leaves everything clear
    always_comb begin
        if (rst_seen_q == 1'b1) begin
            a_r1_reset_clear: assert (cfg_flat == '0 && rdata == '0);
        end
    end

    // R5: a write that misses the bank changes nothing
    a_r5_miss_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hit) |=> $stable(cfg_flat));

    // R3: an all-zero enable half changes nothing
    a_r3_empty_mask: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[WORD_W-1:HALF_W] == '0) |=> $stable(cfg_flat));

    // R4: at most one register selected
    a_r4_single_sel: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

endmodule

// File: tb/sim_cfgbank_top.sv
`timescale 1ns/1ps
module sim_cfgbank_top;
    localparam int NUM_REGS = 8;
    localparam int ADDR_W   = 8;
    localparam int NV       = 10;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [ADDR_W-1:0]      addr = '0;
    logic [31:0]            wdata = '0;
    logic                   wr_en = 1'b0;
    logic                   rd_en = 1'b0;
    logic [31:0]            rdata;
    logic [NUM_REGS*16-1:0] cfg_flat;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [15:0] model [NUM_REGS];

    always #2.5 clk = ~clk;

    cfgbank_top #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .cfg_flat(cfg_flat)
    );

    // {addr[7:0], wdata[31:0]}
    localparam logic [39:0] VEC [NV] = '{
        {8'h00, 32'hFFFF_A5A5},
        {8'h04, 32'h00FF_1234},
        {8'h00, 32'h0F00_0000},
        {8'h1C, 32'hFFFF_FFFF},
        {8'h1C, 32'h8001_0000},
        {8'h08, 32'h0C00_0800},
        {8'h08, 32'h0001_0001},
        {8'h04, 32'hFF00_AB00},
        {8'h10, 32'h0000_FFFF},
        {8'h14, 32'h5555_FFFF}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit valid_addr(input logic [ADDR_W-1:0] a);
        return (a[1:0] == 2'b00) && (int'(a[ADDR_W-1:2]) < NUM_REGS);
    endfunction

    function automatic logic [NUM_REGS*16-1:0] model_flat();
        logic [NUM_REGS*16-1:0] f;
        for (int k = 0; k < NUM_REGS; k++) f[k*16 +: 16] = model[k];
        return f;
    endfunction

    task automatic model_write(input logic [ADDR_W-1:0] a, input logic [31:0] w);
        if (valid_addr(a)) begin
            int i = int'(a[ADDR_W-1:2]);
            model[i] = (model[i] & ~w[31:16]) | (w[15:0] & w[31:16]);
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] w);
        @(negedge clk);
        addr = a; wdata = w; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, w);
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, output logic [31:0] r);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        r = rdata;
    endtask

    task automatic check_all_regs(input string tag);
        logic [31:0] r;
        for (int k = 0; k < NUM_REGS; k++) begin
            do_read(ADDR_W'(k * 4), r);
            check(tag, r, {16'h0, model[k]});
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        for (int k = 0; k < NUM_REGS; k++) model[k] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 cfg_flat after reset", 32'(cfg_flat == '0), 32'd1);
        check("R1 rdata after reset", rdata, 32'h0);

        // Vector walk: R2 R3 R4 R7 R9
        for (int v = 0; v < NV; v++) begin
            do_write(VEC[v][39:32], VEC[v][31:0]);
            check("R7 cfg_flat after vector write", 32'(cfg_flat == model_flat()), 32'd1);
            for (int k = 0; k < NUM_REGS; k++)
                check("R2_R4 register slice", {16'h0, cfg_flat[k*16 +: 16]}, {16'h0, model[k]});
        end
        // R3: vector 8 had zero enables on register 4
        check("R3 empty mask keeps reg4", {16'h0, cfg_flat[4*16 +: 16]}, 32'h0);
        // R9: pin 5 field of register 2 is bits 11:10, set to 2'b10; only bit0 also set
        check("R9 pin field value", {16'h0, cfg_flat[2*16 +: 16]}, 32'h0000_0801);
        check_all_regs("R6 readback after vectors");

        // R5: out-of-range and misaligned writes ignored, reads of them zero
        do_write(8'h20, 32'hFFFF_FFFF);
        check("R5 out of range write", 32'(cfg_flat == model_flat()), 32'd1);
        do_write(8'h05, 32'hFFFF_FFFF);
        check("R5 misaligned write", 32'(cfg_flat == model_flat()), 32'd1);
        do_write(8'h3E, 32'hFFFF_FFFF);
        check("R5 high misaligned write", 32'(cfg_flat == model_flat()), 32'd1);
        do_read(8'h20, r);
        check("R5 read out of range", r, 32'h0);
        do_read(8'h01, r);
        check("R5 read misaligned", r, 32'h0);

        // R6: rdata holds across idle cycles and ignored writes
        do_read(8'h14, r);
        check("R6 read reg5", r, {16'h0, model[5]});
        repeat (3) @(negedge clk);
        check("R6 rdata holds idle", rdata, {16'h0, model[5]});
        do_write(8'h14, 32'hFFFF_0000);
        check("R6 rdata holds over write", rdata, 32'h0000_5555);

        // R8: read and write same register in one cycle
        @(negedge clk);
        addr = 8'h0C; wdata = 32'h00FF_00AA; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R8 read sees old value", rdata, {16'h0, model[3]});
        model_write(8'h0C, 32'h00FF_00AA);
        check("R8 write still lands", {16'h0, cfg_flat[3*16 +: 16]}, 32'h0000_00AA);

        // R2 R4: random masked writes against the model
        for (int n = 0; n < 300; n++) begin
            logic [ADDR_W-1:0] a;
            logic [31:0] w;
            a = ADDR_W'($urandom_range(0, 40));
            if ($urandom_range(0, 3) != 0) a[1:0] = 2'b00;
            w = $urandom;
            do_write(a, w);
            check("R2 random masked write", 32'(cfg_flat == model_flat()), 32'd1);
        end
        check_all_regs("R6 readback after random");

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < NUM_REGS; k++) model[k] = '0;
        check("R1 mid-run reset cfg", 32'(cfg_flat == '0), 32'd1);
        check("R1 mid-run reset rdata", rdata, 32'h0);

        finish_run();
    end

endmodule